// File: doc/BRIEF.md
# Configuration Start-Up Sequencer

This block walks a programmable device from power-up to user operation. Right after reset it pulls the shared, active-low init line low through an open-drain enable while the internal configuration memory is cleared. The clear is modelled as a fixed number of clock cycles. It then lets the line go. As long as anything outside keeps the line low, it waits. When the line rises, it captures a four-bit mode word and starts accepting configuration data. It keeps accepting until a completion input arrives.

After completion, two release timers start. One sets when the done output rises. The other sets when user I/O is enabled and the two "configuration not complete" flags flip. Each timer has its own 2-bit delay option of 0 to 3 cycles, captured when configuration completes. The boundary-scan enable stays on until completion. After completion it stays on only if boundary scan is selected.

The states are:
- CLEAR: drives the line low and counts the clear cycles.
- WAIT: the line is released and the block waits for it to go high.
- CONFIG: the block accepts data.
- RELEASE: the timers run.
- USER: both outputs are released.

The transitions are:
- CLEAR to WAIT when the clear count ends.
- WAIT to CONFIG on a rising edge of the init line.
- CONFIG to RELEASE when the completion input is seen.
- RELEASE to USER once both timers have expired.
- Any state to CLEAR on synchronous reset.

Top module: `cfg_startup_seq`

## Requirements
- R1: `init_oe_o` is 1 while `rst` is high and for exactly CLEAR_CYCLES clock cycles after `rst` falls. It is 0 at all other times.
- R2: After clearing, while `init_in` reads 0, the block keeps waiting. In that time `data_accept_o` stays 0 and `mode_q_o` keeps its reset value of 0.
- R3: On the first clock edge in the wait state at which `init_in` is 1 after having been 0, `mode_sel` is stored into `mode_q_o` and `data_accept_o` becomes 1. Later changes of `mode_sel` leave `mode_q_o` unchanged until reset.
- R4: `hdc_o` is 1 and `ldc_o` is 0 from reset until user I/O is enabled. In the same cycle that `uio_en_o` rises, they flip to 0 and 1.
- R5: `data_accept_o` is 1 only between mode capture and completion. `cfg_done_in` is ignored before data is being accepted.
- R6: Let the completion edge E be the clock edge at which `cfg_done_in` is 1 while `data_accept_o` is 1. `done_o` rises after edge E+`done_dly` (0 to 3) and stays 1 until reset.
- R7: `uio_en_o` rises after edge E+`uio_dly` (0 to 3), independent of `done_dly`, and stays 1 until reset.
- R8: `scan_en_o` is 1 from reset through edge E. After edge E it equals `scan_sel`.
- R9: A synchronous reset from any state returns the block to clearing. On that reset `hdc_o`=1, `ldc_o`=0, `done_o`=0, `uio_en_o`=0, `data_accept_o`=0 and `mode_q_o`=0.
- R10: Both delay options are taken at edge E. Changing `done_dly` or `uio_dly` after edge E does not change the release cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| init_in | input | 1 | Level observed on the shared init line |
| init_oe_o | output | 1 | Open-drain pull-low enable for the init line |
| mode_sel | input | MODE_W | Mode select, sampled on the rising edge of the init line |
| mode_q_o | output | MODE_W | Captured mode word |
| data_accept_o | output | 1 | High while configuration data is accepted |
| cfg_done_in | input | 1 | Configuration complete indication |
| done_dly | input | DLY_W | Done release delay option |
| uio_dly | input | DLY_W | User-I/O release delay option |
| scan_sel | input | 1 | Boundary scan selected for use after configuration |
| scan_en_o | output | 1 | Boundary-scan enable |
| hdc_o | output | 1 | High while configuration is not complete |
| ldc_o | output | 1 | Low while configuration is not complete |
| done_o | output | 1 | Done release |
| uio_en_o | output | 1 | User I/O enable |

## Verification
Three things can happen in the same cycle:
- The done release and the user-I/O release coincide whenever the two delay options are equal.
- With a delay of 0, a release also coincides with the completion edge itself, in the same cycle that `scan_en_o` drops.

The bench sweeps all sixteen pairs of delay options, with both values of `scan_sel`. For each case it computes the expected release cycle of each output as edge E plus its option, and compares every output in every cycle after completion against those numbers. A pair of equal options must show both outputs and the flag flip rising in one cycle.

// File: rtl/cfg_startup_pkg.sv
package cfg_startup_pkg;

    typedef enum logic [2:0] {
        ST_CLEAR,
        ST_WAIT,
        ST_CONFIG,
        ST_RELEASE,
        ST_USER
    } cfg_state_e;

    localparam int NUM_REL = 2;
    localparam int REL_DONE = 0;
    localparam int REL_UIO = 1;

endpackage

// File: rtl/cfg_clear_timer.sv
module cfg_clear_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic last
);
    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST_VAL = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (run && cnt != LAST_VAL) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = run && (cnt == LAST_VAL);

    AST_CLR_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST_VAL); // R1
endmodule

// File: rtl/cfg_init_edge.sv
module cfg_init_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    output logic rise
);
    logic line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_q <= 1'b0;
        end else begin
            line_q <= line_in;
        end
    end

    assign rise = line_in && !line_q;
endmodule

// File: rtl/cfg_release_timer.sv
module cfg_release_timer #(
    parameter int DLY_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             active,
    input  logic [DLY_W-1:0] dly,
    output logic             rel
);
    localparam logic [DLY_W-1:0] CNT_MAX = '1;

    logic [DLY_W-1:0] cnt;
    logic [DLY_W-1:0] dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dly_q <= '0;
        end else if (start) begin
            cnt   <= '0;
            dly_q <= dly;
        end else if (active && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign rel = active && (cnt >= dly_q);

    AST_REL_STICKY: assert property (@(posedge clk) disable iff (rst)
        (rel && !start) |=> rel); // R6
    AST_DLY_HELD: assert property (@(posedge clk) disable iff (rst)
        (active && !start) |=> $stable(dly_q)); // R10
endmodule

// File: rtl/cfg_startup_seq.sv
module cfg_startup_seq
    import cfg_startup_pkg::*;
#(
    parameter int CLEAR_CYCLES = 16,
    parameter int MODE_W = 4,
    parameter int DLY_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_in,
    output logic              init_oe_o,
    input  logic [MODE_W-1:0] mode_sel,
    output logic [MODE_W-1:0] mode_q_o,
    output logic              data_accept_o,
    input  logic              cfg_done_in,
    input  logic [DLY_W-1:0]  done_dly,
    input  logic [DLY_W-1:0]  uio_dly,
    input  logic              scan_sel,
    output logic              scan_en_o,
    output logic              hdc_o,
    output logic              ldc_o,
    output logic              done_o,
    output logic              uio_en_o
);
    cfg_state_e state, state_nx;
    logic clr_last;
    logic init_rise;
    logic complete;
    logic post;
    logic [MODE_W-1:0] mode_q;
    logic [NUM_REL-1:0] rel;
    logic [DLY_W-1:0] dly_sel [NUM_REL];

    cfg_clear_timer #(.CYCLES(CLEAR_CYCLES)) clr_i (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_CLEAR),
        .last (clr_last)
    );

    cfg_init_edge edge_i (
        .clk     (clk),
        .rst     (rst),
        .line_in (init_in),
        .rise    (init_rise)
    );

    assign complete = (state == ST_CONFIG) && cfg_done_in;
    assign post = (state == ST_RELEASE) || (state == ST_USER);
    assign dly_sel[REL_DONE] = done_dly;
    assign dly_sel[REL_UIO] = uio_dly;

    for (genvar g = 0; g < NUM_REL; g++) begin : g_rel
        cfg_release_timer #(.DLY_W(DLY_W)) tmr_i (
            .clk    (clk),
            .rst    (rst),
            .start  (complete),
            .active (post),
            .dly    (dly_sel[g]),
            .rel    (rel[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_CLEAR;
            mode_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_WAIT && init_rise) begin
                mode_q <= mode_sel;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR:   if (clr_last) state_nx = ST_WAIT;
            ST_WAIT:    if (init_rise) state_nx = ST_CONFIG;
            ST_CONFIG:  if (cfg_done_in) state_nx = ST_RELEASE;
            ST_RELEASE: if (&rel) state_nx = ST_USER;
            ST_USER:    state_nx = ST_USER;
            default:    state_nx = ST_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        init_oe_o     = 1'b0;
        data_accept_o = 1'b0;
        scan_en_o     = 1'b1;
        done_o        = 1'b0;
        uio_en_o      = 1'b0;
        unique case (state)
            ST_CLEAR:   init_oe_o = 1'b1;
            ST_WAIT:    init_oe_o = 1'b0;
            ST_CONFIG:  data_accept_o = 1'b1;
            ST_RELEASE: begin
                scan_en_o = scan_sel;
                done_o    = rel[REL_DONE];
                uio_en_o  = rel[REL_UIO];
            end
            ST_USER: begin
                scan_en_o = scan_sel;
                done_o    = 1'b1;
                uio_en_o  = 1'b1;
            end
            default: init_oe_o = 1'b1;
        endcase
        hdc_o    = !uio_en_o;
        ldc_o    = uio_en_o;
        mode_q_o = mode_q;
    end

    AST_CLEAR_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        init_oe_o |-> !data_accept_o); // R1
    AST_HOLD_STALLS: assert property (@(posedge clk) disable iff (rst)
        (!init_in && !init_oe_o && !data_accept_o && !done_o && !uio_en_o) |=> !data_accept_o); // R2
    AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
        data_accept_o |=> $stable(mode_q_o)); // R3
    AST_FLAGS_OPPOSE: assert property (@(posedge clk) disable iff (rst)
        hdc_o != ldc_o); // R4
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_o |=> done_o); // R6
    AST_UIO_STICKY: assert property (@(posedge clk) disable iff (rst)
        uio_en_o |=> (uio_en_o && ldc_o)); // R7
    AST_SCAN_INHIBIT: assert property (@(posedge clk) disable iff (rst)
        (done_o && !scan_sel) |-> !scan_en_o); // R8
endmodule

// File: tb/cfg_startup_seq_tb_top.sv
module cfg_startup_seq_tb_top;
    localparam int NCLR = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_hold = 1'b1;
    logic init_in;
    logic init_oe_o;
    logic [3:0] mode_sel = 4'h0;
    logic [3:0] mode_q_o;
    logic data_accept_o;
    logic cfg_done_in = 1'b0;
    logic [1:0] done_dly = 2'd0;
    logic [1:0] uio_dly = 2'd0;
    logic scan_sel = 1'b0;
    logic scan_en_o, hdc_o, ldc_o, done_o, uio_en_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    assign init_in = !init_oe_o && !ext_hold;

    cfg_startup_seq #(.CLEAR_CYCLES(NCLR), .MODE_W(4), .DLY_W(2)) dut_i (
        .clk(clk), .rst(rst), .init_in(init_in), .init_oe_o(init_oe_o),
        .mode_sel(mode_sel), .mode_q_o(mode_q_o), .data_accept_o(data_accept_o),
        .cfg_done_in(cfg_done_in), .done_dly(done_dly), .uio_dly(uio_dly),
        .scan_sel(scan_sel), .scan_en_o(scan_en_o), .hdc_o(hdc_o), .ldc_o(ldc_o),
        .done_o(done_o), .uio_en_o(uio_en_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk_reset_vals();
        chk("R9", "init_oe", init_oe_o, 1);
        chk("R9", "hdc", hdc_o, 1);
        chk("R9", "ldc", ldc_o, 0);
        chk("R9", "done", done_o, 0);
        chk("R9", "uio", uio_en_o, 0);
        chk("R9", "accept", data_accept_o, 0);
        chk("R9", "mode", mode_q_o, 0);
        chk("R8", "scan_en in reset", scan_en_o, 1);
    endtask

    // one full start-up sequence
    task automatic run_seq(input int hold, input int m, input int dd, input int ud, input int sc);
        rst = 1'b1; ext_hold = 1'b1; cfg_done_in = 1'b0;
        mode_sel = 4'(~m); done_dly = 2'(dd); uio_dly = 2'(ud); scan_sel = 1'(sc);
        step(); step();
        chk_reset_vals();
        rst = 1'b0;
        for (int k = 1; k <= NCLR; k++) begin
            step();
            chk("R1", "init_oe during clear", init_oe_o, (k < NCLR) ? 1 : 0);
        end
        // hold line low from outside; completion pulses must be ignored (R5)
        for (int j = 0; j < hold; j++) begin
            cfg_done_in = 1'b1;
            step();
            chk("R2", "accept while held", data_accept_o, 0);
            chk("R2", "mode while held", mode_q_o, 0);
            chk("R5", "done while held", done_o, 0);
        end
        cfg_done_in = 1'b0;
        mode_sel = 4'(m);
        ext_hold = 1'b0;
        step();
        chk("R3", "accept after rise", data_accept_o, 1);
        chk("R3", "mode captured", mode_q_o, m);
        mode_sel = 4'(~m);
        for (int c = 0; c < 3; c++) begin
            step();
            chk("R3", "mode held", mode_q_o, m);
            chk("R5", "accept in config", data_accept_o, 1);
            chk("R4", "hdc in config", hdc_o, 1);
            chk("R8", "scan_en in config", scan_en_o, 1);
        end
        cfg_done_in = 1'b1;
        step(); // edge E
        cfg_done_in = 1'b0;
        done_dly = 2'(3 - dd);
        uio_dly = 2'(3 - ud);
        for (int t = 0; t <= 4; t++) begin
            chk("R6", "done timing", done_o, (t >= dd) ? 1 : 0);
            chk("R7", "uio timing", uio_en_o, (t >= ud) ? 1 : 0);
            chk("R4", "hdc with uio", hdc_o, (t >= ud) ? 0 : 1);
            chk("R4", "ldc with uio", ldc_o, (t >= ud) ? 1 : 0);
            chk("R8", "scan after completion", scan_en_o, sc);
            chk("R5", "accept after completion", data_accept_o, 0);
            if (t == 4) chk("R10", "both released late", done_o & uio_en_o, 1);
            step();
        end
    endtask

    initial begin
        for (int dd = 0; dd < 4; dd++) begin
            for (int ud = 0; ud < 4; ud++) begin
                for (int sc = 0; sc < 2; sc++) begin
                    run_seq(((dd + ud) % 3) * 2, ((dd * 4 + ud) ^ (sc * 9)) & 15, dd, ud, sc);
                end
            end
        end
        // reset in the middle of configuration
        rst = 1'b1; ext_hold = 1'b1; step(); step();
        rst = 1'b0;
        for (int k = 0; k < NCLR; k++) step();
        mode_sel = 4'hA; ext_hold = 1'b0;
        step();
        chk("R3", "mode before mid reset", mode_q_o, 10);
        rst = 1'b1; ext_hold = 1'b1;
        step();
        chk_reset_vals();
        rst = 1'b0;
        step();
        chk("R9", "clearing again after reset", init_oe_o, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule